// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the frequency-modulation offset that a spread-spectrum clock synthesizer adds to the nominal ratio of its feedback divider. It runs on the reference clock. An internal tick divider, set by the same input-divider value that feeds the phase comparator, fires once every `div_r` reference cycles. Each tick advances an eight-step triangle, so one modulation period lasts 8 × `div_r` reference cycles. The modulation rate is therefore the reference frequency divided by 8R.

Four configurations are built in as parameters. Each holds an enable flag, a spread style (center or down) and a 4-bit magnitude code. A 2-bit select input chooses a configuration while the block runs. The selection is taken only at the start of a triangle period, when the offset is zero, so the synthesized frequency never steps. The output is a signed offset in parts per million, registered, with a one-cycle valid strobe on every tick.

The triangle phase is a ring of eight named states, each left on a tick: `PH_ORIGIN` → `PH_RISE` → `PH_CREST` → `PH_FALL_HI` → `PH_MID` → `PH_FALL_LO` → `PH_TROUGH` → `PH_RETURN` → `PH_ORIGIN`. Without a tick every state holds. Reset forces `PH_ORIGIN`.

Top module: `ss_profile_gen`

## Requirements
- R1: A tick, and with it one cycle of `offset_vld` high, comes every `div_r` clock cycles. A `div_r` of 0 behaves as 1. A new `div_r` written just after a strobe sets the spacing to the next strobe.
- R2: The phase takes eight ticks per period. The strobe presented at each period start (phase 0) carries an offset of exactly 0.
- R3: With an enabled center-spread configuration, the offsets at phases 0..7 are w × 625 × (code+1) ppm, where w = 0, 1, 2, 1, 0, −1, −2, −1. The peak is ±1250 × (code+1).
- R4: With an enabled down-spread configuration, the offsets at phases 0..7 are w × 625 × (code+1) ppm, where w = 0, −1, −2, −3, −4, −3, −2, −1. The offset never rises above 0 and its trough is −2500 × (code+1).
- R5: With a disabled configuration the offset stays exactly 0 at every phase, and the strobe keeps pulsing.
- R6: `sel` is sampled only at the tick that presents phase 0. A change at any other time has no effect until the next period begins.
- R7: A synchronous reset drives the offset to 0 and the strobe low. The triangle restarts at phase 0, and the first strobe after reset carries 0.
- R8: Between strobes `offset_ppm` holds its value.
- R9: The offset spans −40000 ppm (down spread, code 15) to +20000 ppm (center spread, code 15) and fits the 18-bit signed output.
- R10: The default configurations are: 0 = center, code 15, enabled; 1 = down, code 15, enabled; 2 = center, code 4, disabled; 3 = center, code 2, enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_r | input | 9 | Input-divider value R that sets the tick spacing |
| sel | input | 2 | Configuration select |
| offset_ppm | output | 18 | Signed frequency offset in ppm |
| offset_vld | output | 1 | One-cycle strobe when a new offset is presented |

## Verification
The hardest case to reach is a select change partway through a period. It must be ignored for the remaining phases and then take effect exactly at the next phase-0 tick. A change of `div_r` is also hard, because it must line up with the tick counter restart. The bench changes `sel` at random cycles and changes `div_r` only in the cycle right after a strobe. Its model latches the select only at phase 0, so any early adoption shows up as a wrong offset. Directed runs cover `div_r` of 0, 1 and 511, the disabled configuration and both extreme magnitudes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int NUM_PRESETS = 4;
    localparam int SEL_W       = $clog2(NUM_PRESETS);
    localparam int PH_STEPS    = 8;

    typedef struct packed {
        logic       on;
        logic       down;
        logic [3:0] code;
    } preset_t;

    typedef enum logic [2:0] {
        PH_ORIGIN  = 3'd0,
        PH_RISE    = 3'd1,
        PH_CREST   = 3'd2,
        PH_FALL_HI = 3'd3,
        PH_MID     = 3'd4,
        PH_FALL_LO = 3'd5,
        PH_TROUGH  = 3'd6,
        PH_RETURN  = 3'd7
    } phase_e;

endpackage

// File: rtl/ssp_tick_div.sv
module ssp_tick_div #(
    parameter int R_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] div_r,
    output logic           tick
);
    logic [R_W-1:0] cnt_q;
    logic [R_W-1:0] limit;

    // R of zero is treated as one: the tick fires every cycle
    always_comb begin
        if (div_r == '0) limit = '0;
        else             limit = div_r - R_W'(1);
    end

    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + R_W'(1);
    end
endmodule

// File: rtl/ssp_preset_sel.sv
module ssp_preset_sel
    import ssp_pkg::*;
#(
    parameter preset_t [NUM_PRESETS-1:0] PRESETS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             load,
    output preset_t          cfg_act
);
    preset_t table_w [NUM_PRESETS];

    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_tab
        assign table_w[g] = PRESETS[g];
    end

    always_ff @(posedge clk) begin
        if (rst)       cfg_act <= PRESETS[NUM_PRESETS-1];
        else if (load) cfg_act <= table_w[sel];
    end
endmodule

// File: rtl/ssp_phase_fsm.sv
module ssp_phase_fsm
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              down,
    output phase_e            phase,
    output logic signed [3:0] weight
);
    phase_e phase_q, phase_d;
    logic signed [3:0] w_center, w_down;

    // next-state: one step around the ring per tick
    always_comb begin
        phase_d = phase_q;
        if (tick) begin
            unique case (phase_q)
                PH_ORIGIN:  phase_d = PH_RISE;
                PH_RISE:    phase_d = PH_CREST;
                PH_CREST:   phase_d = PH_FALL_HI;
                PH_FALL_HI: phase_d = PH_MID;
                PH_MID:     phase_d = PH_FALL_LO;
                PH_FALL_LO: phase_d = PH_TROUGH;
                PH_TROUGH:  phase_d = PH_RETURN;
                PH_RETURN:  phase_d = PH_ORIGIN;
                default:    phase_d = PH_ORIGIN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ORIGIN;
        else     phase_q <= phase_d;
    end

    // outputs: triangle weight in units of a quarter of the down-spread peak
    always_comb begin
        unique case (phase_q)
            PH_ORIGIN:  begin w_center =  4'sd0; w_down =  4'sd0; end
            PH_RISE:    begin w_center =  4'sd1; w_down = -4'sd1; end
            PH_CREST:   begin w_center =  4'sd2; w_down = -4'sd2; end
            PH_FALL_HI: begin w_center =  4'sd1; w_down = -4'sd3; end
            PH_MID:     begin w_center =  4'sd0; w_down = -4'sd4; end
            PH_FALL_LO: begin w_center = -4'sd1; w_down = -4'sd3; end
            PH_TROUGH:  begin w_center = -4'sd2; w_down = -4'sd2; end
            PH_RETURN:  begin w_center = -4'sd1; w_down = -4'sd1; end
            default:    begin w_center =  4'sd0; w_down =  4'sd0; end
        endcase
        weight = down ? w_down : w_center;
    end

    assign phase = phase_q;
endmodule

// File: rtl/ssp_scale.sv
module ssp_scale
    import ssp_pkg::*;
#(
    parameter int OFF_W    = 18,
    parameter int STEP_PPM = 625
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  preset_t                 cfg,
    input  logic signed [3:0]       weight,
    output logic signed [OFF_W-1:0] offset,
    output logic                    vld
);
    logic        [OFF_W-1:0] mag_u;
    logic signed [OFF_W-1:0] w_ext;
    logic signed [OFF_W-1:0] prod;

    always_comb begin
        mag_u = OFF_W'(STEP_PPM) * OFF_W'({1'b0, cfg.code} + 5'd1);
        w_ext = OFF_W'(weight);
        prod  = cfg.on ? (w_ext * $signed(mag_u)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= tick;
            if (tick) offset <= prod;
        end
    end
endmodule

// File: rtl/ss_profile_gen.sv
module ss_profile_gen
    import ssp_pkg::*;
#(
    parameter int R_W      = 9,
    parameter int OFF_W    = 18,
    parameter int STEP_PPM = 625,
    parameter preset_t [NUM_PRESETS-1:0] PRESETS = '{
        3: '{on: 1'b1, down: 1'b0, code: 4'd2},
        2: '{on: 1'b0, down: 1'b0, code: 4'd4},
        1: '{on: 1'b1, down: 1'b1, code: 4'd15},
        0: '{on: 1'b1, down: 1'b0, code: 4'd15}
    }
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [R_W-1:0]          div_r,
    input  logic [SEL_W-1:0]        sel,
    output logic signed [OFF_W-1:0] offset_ppm,
    output logic                    offset_vld
);
    logic              tick;
    logic              load;
    preset_t           cfg_act;
    phase_e            phase;
    logic signed [3:0] weight;

    ssp_tick_div #(.R_W(R_W)) i_tick (
        .clk(clk), .rst(rst), .div_r(div_r), .tick(tick)
    );

    // configuration swaps only when the tick presents the period start
    assign load = tick && (phase == PH_ORIGIN);

    ssp_preset_sel #(.PRESETS(PRESETS)) i_sel (
        .clk(clk), .rst(rst), .sel(sel), .load(load), .cfg_act(cfg_act)
    );

    ssp_phase_fsm i_fsm (
        .clk(clk), .rst(rst), .tick(tick), .down(cfg_act.down),
        .phase(phase), .weight(weight)
    );

    ssp_scale #(.OFF_W(OFF_W), .STEP_PPM(STEP_PPM)) i_scale (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg_act), .weight(weight),
        .offset(offset_ppm), .vld(offset_vld)
    );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
    import ssp_pkg::*;
#(
    parameter int OFF_W    = 18,
    parameter int STEP_PPM = 625
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input phase_e                  phase,
    input preset_t                 cfg_act,
    input logic signed [OFF_W-1:0] offset_ppm,
    input logic                    offset_vld
);
    localparam int MAX_POS = 2 * 16 * STEP_PPM;
    localparam int MAX_NEG = -4 * 16 * STEP_PPM;

    p_period_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (offset_vld && phase == PH_RISE) |-> offset_ppm == '0);

    p_down_nonpos_r4: assert property (@(posedge clk) disable iff (rst)
        (offset_vld && cfg_act.down) |-> offset_ppm <= 0);

    p_disabled_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (offset_vld && !cfg_act.on) |-> offset_ppm == '0);

    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !(tick && phase == PH_ORIGIN) |=> $stable(cfg_act));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (offset_ppm == '0 && !offset_vld));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !offset_vld |-> $stable(offset_ppm));

    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(offset_ppm) >= MAX_NEG) && (int'(offset_ppm) <= MAX_POS));
endmodule

bind ss_profile_gen ssp_checker #(.OFF_W(OFF_W), .STEP_PPM(STEP_PPM)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .phase(phase), .cfg_act(cfg_act),
    .offset_ppm(offset_ppm), .offset_vld(offset_vld)
);

// File: tb/test_ss_profile_gen.sv
`timescale 1ns/1ps
module test_ss_profile_gen;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [8:0]         div_r = 9'd3;
    logic [1:0]         sel = 2'd0;
    logic signed [17:0] offset_ppm;
    logic               offset_vld;

    always #2 clk = ~clk;

    ss_profile_gen i_ss_profile_gen (
        .clk(clk), .rst(rst), .div_r(div_r), .sel(sel),
        .offset_ppm(offset_ppm), .offset_vld(offset_vld)
    );

    int checks = 0, errors = 0;
    int ph = 0, cur_p = 3, gap = 0, ticks = 0;
    int last_off = 0, seen_min = 0, seen_max = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_r(int r);
        return (r == 0) ? 1 : r;
    endfunction

    // R10 default table: {on, down, code}
    function automatic int exp_off(int p, int phase_i);
        int wc [8] = '{0, 1, 2, 1, 0, -1, -2, -1};
        int wd [8] = '{0, -1, -2, -3, -4, -3, -2, -1};
        bit on, dn; int code;
        case (p)
            0: begin on = 1; dn = 0; code = 15; end
            1: begin on = 1; dn = 1; code = 15; end
            2: begin on = 0; dn = 0; code = 4;  end
            default: begin on = 1; dn = 0; code = 2; end
        endcase
        if (!on) return 0;
        return (dn ? wd[phase_i] : wc[phase_i]) * 625 * (code + 1);
    endfunction

    task automatic step();
        int e; string tag;
        @(negedge clk);
        gap++;
        if (offset_vld) begin
            chk(gap == eff_r(int'(div_r)), "R1 tick spacing", gap, eff_r(int'(div_r)));
            if (ph == 0) cur_p = int'(sel);
            e = exp_off(cur_p, ph);
            if (ph == 0)                 tag = "R2 period start";
            else if (int'(sel) != cur_p) tag = "R6 deferred select";
            else if (cur_p == 2)         tag = "R5 disabled";
            else if (cur_p == 1)         tag = "R4 down spread";
            else                         tag = "R3 center spread";
            chk(int'(offset_ppm) == e, tag, int'(offset_ppm), e);
            if (int'(offset_ppm) < seen_min) seen_min = int'(offset_ppm);
            if (int'(offset_ppm) > seen_max) seen_max = int'(offset_ppm);
            ph = (ph + 1) % 8;
            gap = 0;
            ticks++;
        end else begin
            chk(int'(offset_ppm) == last_off, "R8 hold", int'(offset_ppm), last_off);
        end
        last_off = int'(offset_ppm);
    endtask

    task automatic do_reset(int n);
        rst = 1'b1;
        repeat (n) begin
            @(negedge clk);
            chk(offset_ppm == 0 && !offset_vld, "R7 reset",
                int'(offset_ppm) + (offset_vld ? 1000000 : 0), 0);
        end
        rst = 1'b0;
        ph = 0; gap = 0; last_off = 0;
    endtask

    task automatic run_ticks(int n);
        int target = ticks + n;
        while (ticks < target) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(3);
        // center, max code, R=3
        sel = 2'd0; div_r = 9'd3;
        run_ticks(16);
        chk(seen_max == 20000, "R9 center peak", seen_max, 20000);
        // down, max code, R=1
        div_r = 9'd1; sel = 2'd1;
        run_ticks(16);
        chk(seen_min == -40000, "R9 down trough", seen_min, -40000);
        // disabled preset with R=0
        div_r = 9'd0; sel = 2'd2;
        run_ticks(16);
        // small center code with the largest R
        sel = 2'd3; div_r = 9'd511;
        run_ticks(9);
        div_r = 9'd2;
        run_ticks(7);
        // reset in the middle of a period
        do_reset(2);
        run_ticks(4);
        // random mix
        for (int i = 0; i < 8000; i++) begin
            step();
            if ($urandom % 7 == 0) sel = 2'($urandom);
            if (gap == 0 && ($urandom % 5 == 0)) div_r = 9'($urandom % 12);
            if ($urandom % 900 == 0) do_reset(2);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule